// File: doc/BRIEF.md
# Byte Store Micro-Sequencer

This block fetches and executes the 8-bit store instructions of a classic 8-bit processor (store accumulator, store X, store Y) over a simple single-port synchronous memory bus. Each instruction begins with an opcode fetch. The block then reads its operand bytes, forms the effective address for the addressing mode, and ends with exactly one data write. Every bus cycle carries exactly one access, so each addressing mode always takes the same fixed number of clocks. A page crossing never adds a cycle.

Immediate loads of A, X and Y are also decoded, so that a program can set up the source and index registers. Any other opcode byte is skipped as a two-cycle no-op. Execution starts from a program counter given as a parameter. A one-cycle `instr_done` pulse marks the last cycle of every instruction.

The bus outputs are registered. The memory must return read data combinationally within the same cycle, and the block captures that data at the closing clock edge.

Top module: `store_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the block presents a read of address START_PC with no write and `instr_done` low.
- R2: Immediate loads (0xA9 into A, 0xA2 into X, 0xA0 into Y) take 2 cycles, consume one operand byte and issue no write.
- R3: Zero-page stores (0x85 A, 0x86 X, 0x84 Y) take 3 cycles and write to address 0x00nn, where nn is the operand.
- R4: Zero-page indexed stores take 4 cycles. They are 0x95 (A, indexed by X), 0x94 (Y, indexed by X) and 0x96 (X, indexed by Y). The target is (operand + index) mod 256 in page zero, so 0x84 + 0xFF writes 0x0083.
- R5: Absolute stores (0x8D A, 0x8E X, 0x8C Y) take 4 cycles. The two operand bytes are little-endian, so 0x41 then 0x03 addresses 0x0341.
- R6: Absolute indexed stores take 5 cycles: 0x9D (A, indexed by X) and 0x99 (A, indexed by Y). The index is added with carry into the high byte. A page crossing adds no cycle.
- R7: Store A with pre-indexed indirect addressing (0x81) takes 6 cycles. The pointer is (operand + X) mod 256. The low target byte is read at the pointer and the high byte at (pointer + 1) mod 256.
- R8: Store A with post-indexed indirect addressing (0x91) takes 6 cycles. A 16-bit base is read from the operand location and from (operand + 1) mod 256, then Y is added with carry. A page crossing adds no cycle.
- R9: Each store issues exactly one write, in its final cycle, together with `instr_done`. The following cycle is an opcode fetch read.
- R10: The written byte equals the source register, including 0x00 and 0x80. The source register keeps its value, so a second store of the same register writes the same byte.
- R11: The program counter wraps from 0xFFFF to 0x0000 while fetching operand bytes.
- R12: Any unlisted opcode takes 2 cycles, issues no write, and the next opcode is fetched from the byte right after it.
- R13: Read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Read data for the current cycle's address |
| mem_addr | output | 16 | Address of the current bus access |
| mem_rd | output | 1 | Current access is a read |
| mem_wr | output | 1 | Current access is a write |
| mem_wdata | output | 8 | Data written when `mem_wr` is high |
| instr_done | output | 1 | High in the last cycle of each instruction |

## Verification
The hardest cases to reach are the two wrap-arounds hidden inside the indirect modes. The first is a pointer of 0xFF, whose high byte must come from 0x0000 and not from 0x0100. The second is a base plus Y that carries into the next page without stretching the instruction. The bench starts every program at 0xFFFC, so the opcode bytes land at 0x0000. It then plants a pointer at 0x00FF. Because location 0x0000 holds a known instruction byte, a correct zero-page wrap yields a distinctive high address, while a wrong wrap would yield one in page zero. The same start address also makes an absolute operand straddle the program counter wrap.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2 * DATA_W;
  localparam int NUM_REGS = 3;
  localparam int STEP_W   = 3;
  localparam int MAX_CYC  = 6;

  localparam int IDX_A = 0;
  localparam int IDX_X = 1;
  localparam int IDX_Y = 2;

  typedef enum logic [2:0] {
    AM_IMM, AM_ZP, AM_ZPI, AM_ABS, AM_ABI, AM_INX, AM_INY, AM_BAD
  } amode_e;

  typedef enum logic [1:0] {RS_A, RS_X, RS_Y, RS_NONE} rsel_e;

  typedef struct packed {
    amode_e mode;
    rsel_e  src;
    rsel_e  idx;
  } dec_t;

  localparam logic [DATA_W-1:0] OP_A_ZP  = 8'h85;
  localparam logic [DATA_W-1:0] OP_A_ZPX = 8'h95;
  localparam logic [DATA_W-1:0] OP_A_ABS = 8'h8D;
  localparam logic [DATA_W-1:0] OP_A_ABX = 8'h9D;
  localparam logic [DATA_W-1:0] OP_A_ABY = 8'h99;
  localparam logic [DATA_W-1:0] OP_A_INX = 8'h81;
  localparam logic [DATA_W-1:0] OP_A_INY = 8'h91;
  localparam logic [DATA_W-1:0] OP_X_ZP  = 8'h86;
  localparam logic [DATA_W-1:0] OP_X_ZPY = 8'h96;
  localparam logic [DATA_W-1:0] OP_X_ABS = 8'h8E;
  localparam logic [DATA_W-1:0] OP_Y_ZP  = 8'h84;
  localparam logic [DATA_W-1:0] OP_Y_ZPX = 8'h94;
  localparam logic [DATA_W-1:0] OP_Y_ABS = 8'h8C;
  localparam logic [DATA_W-1:0] OP_LD_A  = 8'hA9;
  localparam logic [DATA_W-1:0] OP_LD_X  = 8'hA2;
  localparam logic [DATA_W-1:0] OP_LD_Y  = 8'hA0;
endpackage

// File: rtl/store_seq_decode.sv
module store_seq_decode
  import store_seq_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output dec_t              dec
);
  always_comb begin
    dec = '{mode: AM_BAD, src: RS_NONE, idx: RS_NONE};
    case (opcode)
      OP_A_ZP:  dec = '{mode: AM_ZP,  src: RS_A, idx: RS_NONE};
      OP_A_ZPX: dec = '{mode: AM_ZPI, src: RS_A, idx: RS_X};
      OP_A_ABS: dec = '{mode: AM_ABS, src: RS_A, idx: RS_NONE};
      OP_A_ABX: dec = '{mode: AM_ABI, src: RS_A, idx: RS_X};
      OP_A_ABY: dec = '{mode: AM_ABI, src: RS_A, idx: RS_Y};
      OP_A_INX: dec = '{mode: AM_INX, src: RS_A, idx: RS_X};
      OP_A_INY: dec = '{mode: AM_INY, src: RS_A, idx: RS_Y};
      OP_X_ZP:  dec = '{mode: AM_ZP,  src: RS_X, idx: RS_NONE};
      OP_X_ZPY: dec = '{mode: AM_ZPI, src: RS_X, idx: RS_Y};
      OP_X_ABS: dec = '{mode: AM_ABS, src: RS_X, idx: RS_NONE};
      OP_Y_ZP:  dec = '{mode: AM_ZP,  src: RS_Y, idx: RS_NONE};
      OP_Y_ZPX: dec = '{mode: AM_ZPI, src: RS_Y, idx: RS_X};
      OP_Y_ABS: dec = '{mode: AM_ABS, src: RS_Y, idx: RS_NONE};
      OP_LD_A:  dec = '{mode: AM_IMM, src: RS_A, idx: RS_NONE};
      OP_LD_X:  dec = '{mode: AM_IMM, src: RS_X, idx: RS_NONE};
      OP_LD_Y:  dec = '{mode: AM_IMM, src: RS_Y, idx: RS_NONE};
      default:  dec = '{mode: AM_BAD, src: RS_NONE, idx: RS_NONE};
    endcase
  end
endmodule

// File: rtl/store_seq_regfile.sv
module store_seq_regfile
  import store_seq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REGS-1:0]        we,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)        r_q <= '0;
      else if (we[g]) r_q <= wdata;
    end
    assign q[g*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/store_seq_agen.sv
module store_seq_agen
  import store_seq_pkg::*;
(
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] idx,
  output logic [DATA_W-1:0] low_sum,
  output logic [ADDR_W-1:0] page_addr,
  output logic [ADDR_W-1:0] full_addr
);
  // Low-byte sum wraps inside the byte; the full sum carries into hi.
  assign low_sum   = lo + idx;
  assign page_addr = {hi, low_sum};
  assign full_addr = {hi, lo} + {{DATA_W{1'b0}}, idx};
endmodule

// File: rtl/store_seq.sv
module store_seq
  import store_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              instr_done
);
  localparam logic [DATA_W-1:0] ZERO_B = '0;

  logic [ADDR_W-1:0] pc_q, pc_n, addr_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [DATA_W-1:0] lo_q, lo_n, hi_q, hi_n, ptr_q, ptr_n;
  logic              rd_n, wr_n, done_n;
  logic [DATA_W-1:0] wdata_n;
  dec_t              cur_q, cur_n, dec_w, op;

  logic [NUM_REGS-1:0]        rf_we;
  logic [NUM_REGS*DATA_W-1:0] rf_q;
  logic [DATA_W-1:0]          reg_a, reg_x, reg_y, src_val, idx_val;
  logic [DATA_W-1:0]          ag_hi, ag_low;
  logic [ADDR_W-1:0]          ag_page, ag_full;
  logic [DATA_W-1:0]          ptr_inc;

  store_seq_decode u_dec (.opcode(mem_rdata), .dec(dec_w));

  store_seq_regfile u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wdata(mem_rdata), .q(rf_q)
  );

  assign reg_a = rf_q[IDX_A*DATA_W +: DATA_W];
  assign reg_x = rf_q[IDX_X*DATA_W +: DATA_W];
  assign reg_y = rf_q[IDX_Y*DATA_W +: DATA_W];

  assign op = (step_q == '0) ? dec_w : cur_q;

  always_comb begin
    case (op.src)
      RS_A:    src_val = reg_a;
      RS_X:    src_val = reg_x;
      RS_Y:    src_val = reg_y;
      default: src_val = '0;
    endcase
    case (op.idx)
      RS_X:    idx_val = reg_x;
      RS_Y:    idx_val = reg_y;
      default: idx_val = '0;
    endcase
  end

  // High byte arrives on the bus in the cycle that needs the page-local address.
  assign ag_hi = ((op.mode == AM_ABI && step_q == 3'd2) ||
                  (op.mode == AM_INY && step_q == 3'd3)) ? mem_rdata : hi_q;
  assign ptr_inc = ptr_q + 1'b1;

  store_seq_agen u_agen (
    .lo(lo_q), .hi(ag_hi), .idx(idx_val),
    .low_sum(ag_low), .page_addr(ag_page), .full_addr(ag_full)
  );

  always_comb begin
    pc_n    = pc_q;
    step_n  = step_q + 1'b1;
    cur_n   = cur_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    ptr_n   = ptr_q;
    addr_n  = pc_q;
    rd_n    = 1'b1;
    wr_n    = 1'b0;
    done_n  = 1'b0;
    wdata_n = '0;
    rf_we   = '0;
    if (instr_done) begin
      step_n = '0;
      if (op.mode == AM_IMM) begin
        pc_n   = pc_q + 1'b1;
        addr_n = pc_q + 1'b1;
        case (op.src)
          RS_A:    rf_we[IDX_A] = 1'b1;
          RS_X:    rf_we[IDX_X] = 1'b1;
          RS_Y:    rf_we[IDX_Y] = 1'b1;
          default: rf_we = '0;
        endcase
      end
    end else begin
      case (step_q)
        3'd0: begin
          cur_n  = dec_w;
          pc_n   = pc_q + 1'b1;
          addr_n = pc_q + 1'b1;
          done_n = (dec_w.mode == AM_IMM) || (dec_w.mode == AM_BAD);
        end
        3'd1: begin
          lo_n   = mem_rdata;
          ptr_n  = mem_rdata;
          pc_n   = pc_q + 1'b1;
          addr_n = {ZERO_B, mem_rdata};
          case (op.mode)
            AM_ZP: begin
              rd_n = 1'b0; wr_n = 1'b1; done_n = 1'b1; wdata_n = src_val;
            end
            AM_ABS, AM_ABI: addr_n = pc_q + 1'b1;
            default: ;
          endcase
        end
        3'd2: begin
          case (op.mode)
            AM_ZPI: begin
              addr_n = {ZERO_B, ag_low};
              rd_n = 1'b0; wr_n = 1'b1; done_n = 1'b1; wdata_n = src_val;
            end
            AM_ABS: begin
              hi_n   = mem_rdata;
              pc_n   = pc_q + 1'b1;
              addr_n = {mem_rdata, lo_q};
              rd_n = 1'b0; wr_n = 1'b1; done_n = 1'b1; wdata_n = src_val;
            end
            AM_ABI: begin
              hi_n   = mem_rdata;
              pc_n   = pc_q + 1'b1;
              addr_n = ag_page;
            end
            AM_INX: begin
              ptr_n  = ag_low;
              addr_n = {ZERO_B, ag_low};
            end
            AM_INY: begin
              lo_n   = mem_rdata;
              addr_n = {ZERO_B, ptr_inc};
            end
            default: ;
          endcase
        end
        3'd3: begin
          case (op.mode)
            AM_ABI: begin
              addr_n = ag_full;
              rd_n = 1'b0; wr_n = 1'b1; done_n = 1'b1; wdata_n = src_val;
            end
            AM_INX: begin
              lo_n   = mem_rdata;
              addr_n = {ZERO_B, ptr_inc};
            end
            AM_INY: begin
              hi_n   = mem_rdata;
              addr_n = ag_page;
            end
            default: ;
          endcase
        end
        3'd4: begin
          case (op.mode)
            AM_INX: begin
              hi_n   = mem_rdata;
              addr_n = {mem_rdata, lo_q};
              rd_n = 1'b0; wr_n = 1'b1; done_n = 1'b1; wdata_n = src_val;
            end
            AM_INY: begin
              addr_n = ag_full;
              rd_n = 1'b0; wr_n = 1'b1; done_n = 1'b1; wdata_n = src_val;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= START_PC;
      step_q     <= '0;
      cur_q      <= '{mode: AM_BAD, src: RS_NONE, idx: RS_NONE};
      lo_q       <= '0;
      hi_q       <= '0;
      ptr_q      <= '0;
      mem_addr   <= START_PC;
      mem_rd     <= 1'b1;
      mem_wr     <= 1'b0;
      mem_wdata  <= '0;
      instr_done <= 1'b0;
    end else begin
      pc_q       <= pc_n;
      step_q     <= step_n;
      cur_q      <= cur_n;
      lo_q       <= lo_n;
      hi_q       <= hi_n;
      ptr_q      <= ptr_n;
      mem_addr   <= addr_n;
      mem_rd     <= rd_n;
      mem_wr     <= wr_n;
      mem_wdata  <= wdata_n;
      instr_done <= done_n;
    end
  end
endmodule

// File: rtl/store_seq_chk.sv
module store_seq_chk
  import store_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_PC = 16'h0200
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              instr_done
);
  logic [STEP_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst)             len_q <= '0;
    else if (instr_done) len_q <= '0;
    else                 len_q <= len_q + 1'b1;
  end

  assert_excl_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_write_last_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> instr_done);

  assert_fetch_follows_R9: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> (mem_rd && !mem_wr));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == START_PC && mem_rd && !mem_wr && !instr_done));

  // R6 R8: no instruction runs past the longest fixed count
  assert_len_cap_R8: assert property (@(posedge clk) disable iff (rst)
    len_q < STEP_W'(MAX_CYC));
endmodule

bind store_seq store_seq_chk #(.START_PC(START_PC)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .instr_done(instr_done)
);

// File: tb/store_seq_bench.sv
module store_seq_bench;
  localparam logic [15:0] START = 16'hFFFC;
  localparam int MEM_AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, instr_done;
  logic [7:0]  mem_wdata;

  logic [7:0] mem [1<<MEM_AW];

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[MEM_AW-1:0]];

  store_seq #(.START_PC(START)) u_store_seq (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .instr_done(instr_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  // observation log, filled at the falling edge
  int cyc, ndone, nwr, nboth;
  int dur [16];
  logic [15:0] wa [8];
  logic [7:0]  wd [8];
  logic        wdn [8];

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; ndone = 0; nwr = 0; nboth = 0;
    end else begin
      cyc++;
      if (mem_rd && mem_wr) nboth++;
      if (mem_wr) begin
        if (nwr < 8) begin
          wa[nwr] = mem_addr; wd[nwr] = mem_wdata; wdn[nwr] = instr_done;
        end
        nwr++;
      end
      if (instr_done) begin
        if (ndone < 16) dur[ndone] = cyc;
        ndone++;
        cyc = 0;
      end
    end
  end

  int          edur [16];
  string       etag [16];
  logic [15:0] ewa [8];
  logic [7:0]  ewd [8];
  string       ewtag [8];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic begin_case();
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = 8'h00;
  endtask

  task automatic pb(input int i, input logic [7:0] v);
    logic [15:0] a;
    a = START + 16'(i);
    mem[a[MEM_AW-1:0]] = v;
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] v);
    mem[a[MEM_AW-1:0]] = v;
  endtask

  task automatic exp_i(input int i, input int d, input string t);
    edur[i] = d; etag[i] = t;
  endtask

  task automatic exp_w(input int i, input logic [15:0] a, input logic [7:0] d,
                       input string t);
    ewa[i] = a; ewd[i] = d; ewtag[i] = t;
  endtask

  task automatic run_check(input int n_ins, input int n_w);
    int waited;
    @(posedge clk); #1 rst = 1'b0;
    waited = 0;
    while (ndone < n_ins && waited < 400) begin
      @(negedge clk); waited++;
    end
    #1;
    check(ndone >= n_ins, "R9", "instructions completed", 16'(ndone), 16'(n_ins));
    for (int i = 0; i < n_ins; i++)
      check(dur[i] == edur[i], etag[i], "instruction cycles", 16'(dur[i]), 16'(edur[i]));
    check(nwr == n_w, "R9", "write count", 16'(nwr), 16'(n_w));
    for (int i = 0; i < n_w && i < nwr; i++) begin
      check(wa[i] == ewa[i], ewtag[i], "write address", wa[i], ewa[i]);
      check(wd[i] == ewd[i], "R10", "write data", 16'(wd[i]), 16'(ewd[i]));
      check(wdn[i], "R9", "write with done", 16'(wdn[i]), 16'd1);
    end
    check(nboth == 0, "R13", "read+write cycles", 16'(nboth), 16'd0);
  endtask

  task automatic t_reset();
    begin_case();
    @(negedge clk);
    check(mem_addr == START, "R1", "reset address", mem_addr, START);
    check(mem_rd == 1'b1, "R1", "reset read strobe", 16'(mem_rd), 16'd1);
    check(mem_wr == 1'b0, "R1", "reset write strobe", 16'(mem_wr), 16'd0);
    check(instr_done == 1'b0, "R1", "reset done", 16'(instr_done), 16'd0);
  endtask

  task automatic t_zero_page();
    begin_case();
    pb(0, 8'hA9); pb(1, 8'h37); pb(2, 8'h85); pb(3, 8'h42);
    exp_i(0, 2, "R2"); exp_i(1, 3, "R3");
    exp_w(0, 16'h0042, 8'h37, "R3");
    run_check(2, 1);
  endtask

  task automatic t_zp_indexed();
    begin_case();
    pb(0, 8'hA2); pb(1, 8'hFF); pb(2, 8'hA0); pb(3, 8'h37);
    pb(4, 8'h94); pb(5, 8'h84);
    pb(6, 8'hA0); pb(7, 8'h02); pb(8, 8'hA2); pb(9, 8'h80);
    pb(10, 8'h96); pb(11, 8'h42);
    exp_i(0, 2, "R2"); exp_i(1, 2, "R2"); exp_i(2, 4, "R4");
    exp_i(3, 2, "R2"); exp_i(4, 2, "R2"); exp_i(5, 4, "R4");
    exp_w(0, 16'h0083, 8'h37, "R4");
    exp_w(1, 16'h0044, 8'h80, "R4");
    run_check(6, 2);
  endtask

  task automatic t_absolute();
    begin_case();
    pb(0, 8'hA2); pb(1, 8'h00);
    pb(2, 8'h8E); pb(3, 8'h41); pb(4, 8'h03);
    pb(5, 8'hA0); pb(6, 8'h80);
    pb(7, 8'h8C); pb(8, 8'h41); pb(9, 8'h02);
    pb(10, 8'hA9); pb(11, 8'h55);
    pb(12, 8'h8D); pb(13, 8'h42); pb(14, 8'h03);
    pb(15, 8'h8C); pb(16, 8'h43); pb(17, 8'h03);
    exp_i(0, 2, "R2"); exp_i(1, 4, "R11"); exp_i(2, 2, "R2");
    exp_i(3, 4, "R5"); exp_i(4, 2, "R2"); exp_i(5, 4, "R5"); exp_i(6, 4, "R10");
    exp_w(0, 16'h0341, 8'h00, "R11");
    exp_w(1, 16'h0241, 8'h80, "R5");
    exp_w(2, 16'h0342, 8'h55, "R5");
    exp_w(3, 16'h0343, 8'h80, "R10");
    run_check(7, 4);
  endtask

  task automatic t_abs_indexed();
    begin_case();
    pb(0, 8'hA2); pb(1, 8'h02); pb(2, 8'hA0); pb(3, 8'hFF);
    pb(4, 8'hA9); pb(5, 8'h37);
    pb(6, 8'h9D); pb(7, 8'h42); pb(8, 8'h02);
    pb(9, 8'h99); pb(10, 8'h80); pb(11, 8'h04);
    exp_i(0, 2, "R2"); exp_i(1, 2, "R2"); exp_i(2, 2, "R2");
    exp_i(3, 5, "R6"); exp_i(4, 5, "R6");
    exp_w(0, 16'h0244, 8'h37, "R6");
    exp_w(1, 16'h057F, 8'h37, "R6");
    run_check(5, 2);
  endtask

  task automatic t_pre_indexed();
    begin_case();
    pb(0, 8'hA2); pb(1, 8'h02); pb(2, 8'hA9); pb(3, 8'h37);
    pb(4, 8'h81); pb(5, 8'h22);
    pb(6, 8'hA2); pb(7, 8'h01);
    pb(8, 8'h81); pb(9, 8'hFE);
    poke(16'h0024, 8'h80); poke(16'h0025, 8'h04); poke(16'h00FF, 8'h60);
    exp_i(0, 2, "R2"); exp_i(1, 2, "R2"); exp_i(2, 6, "R7");
    exp_i(3, 2, "R2"); exp_i(4, 6, "R7");
    exp_w(0, 16'h0480, 8'h37, "R7");
    // pointer 0xFF: high byte from 0x0000, which holds opcode 0x81
    exp_w(1, 16'h8160, 8'h37, "R7");
    run_check(5, 2);
  endtask

  task automatic t_post_indexed();
    begin_case();
    pb(0, 8'hA0); pb(1, 8'hFF); pb(2, 8'hA9); pb(3, 8'h37);
    pb(4, 8'h91); pb(5, 8'h22);
    pb(6, 8'hA0); pb(7, 8'h01);
    pb(8, 8'h91); pb(9, 8'hFF);
    poke(16'h0022, 8'h80); poke(16'h0023, 8'h04); poke(16'h00FF, 8'h10);
    exp_i(0, 2, "R2"); exp_i(1, 2, "R2"); exp_i(2, 6, "R8");
    exp_i(3, 2, "R2"); exp_i(4, 6, "R8");
    exp_w(0, 16'h057F, 8'h37, "R8");
    // base read from 0x00FF and 0x0000 (opcode 0x91): 0x9110 + 1
    exp_w(1, 16'h9111, 8'h37, "R8");
    run_check(5, 2);
  endtask

  task automatic t_unknown_op();
    begin_case();
    pb(0, 8'hA9); pb(1, 8'h12); pb(2, 8'hEA); pb(3, 8'h85); pb(4, 8'h50);
    exp_i(0, 2, "R2"); exp_i(1, 2, "R12"); exp_i(2, 3, "R12");
    exp_w(0, 16'h0050, 8'h12, "R12");
    run_check(3, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_page();
    t_zp_indexed();
    t_absolute();
    t_abs_indexed();
    t_pre_indexed();
    t_post_indexed();
    t_unknown_op();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule